// File: doc/BRIEF.md
# Two-Wire Bus Event Monitor

This block listens to the clock and data lines of a two-wire serial bus without ever driving them. It recovers START and STOP conditions from the line levels and counts the clock pulses that complete inside each frame. From these it produces single-cycle event strobes for a START, a STOP, a STOP that ends a well-formed transfer while the local port acts as a slave, a malformed frame, and each completed byte. It also produces an interrupt request pulse.

The interrupt is gated by two plain control inputs. `slave_active` says that the local port is currently the addressed slave. `monitor_en` makes the port report every action on the bus, whether or not it takes part. With monitoring on, the interrupt fires for each START, each byte and each STOP. With monitoring off, a START never reaches the interrupt.

The lines are raw pins, so they pass through a synchroniser inside the block. All outputs are strobes with no back-pressure, because a passive observer cannot stall the bus. The block has no data stream, so there is no valid/ready handshake.

Top module: `twb_event_mon`

## Requirements
- R1: `ev_start` pulses for exactly one cycle for every SDA fall while SCL is high. This includes a repeated START inside a frame.
- R2: `ev_stop` pulses for exactly one cycle for every SDA rise while SCL is high. It never pulses in the same cycle as `ev_start`.
- R3: Between a START and the next STOP, the block counts each complete SCL pulse (a rise followed by a fall). The pulse during which a START or STOP occurs is not counted. `ev_byte` pulses when the 8th pulse of a byte completes. The count returns to zero after the 9th (acknowledge) pulse and at every START. SCL pulses outside a frame are ignored.
- R4: `ev_bus_err` pulses together with `ev_stop` when the pulse count at the STOP is anything other than 0 or 8. The count is 0 after a whole byte plus its acknowledge, and 8 after a whole byte without it.
- R5: `ev_slave_stop` pulses together with `ev_stop` only when `slave_active` is high and the STOP is not a bus error.
- R6: With `monitor_en` low, `irq` pulses for a bus error, for a slave stop, and for a byte only when `slave_active` is high. A START or a plain STOP alone raises no `irq`.
- R7: With `monitor_en` high, `irq` also pulses for every START, every byte and every STOP. Events in the same cycle give a single `irq` pulse.
- R8: An edge on a line input shows up on the matching strobe 3 clock cycles later: two synchroniser stages plus one output register. Every strobe is one cycle wide.
- R9: While `rst_n` is low, all strobes and `irq` are low. Reset also clears the frame state and the pulse count, so after reset a STOP with no START is not a bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw serial clock line level |
| sda_in | input | 1 | Raw serial data line level |
| monitor_en | input | 1 | Report every bus action on the interrupt |
| slave_active | input | 1 | Local port is the addressed slave |
| ev_start | output | 1 | START (or repeated START) detected |
| ev_stop | output | 1 | STOP detected |
| ev_slave_stop | output | 1 | Well-formed STOP while acting as slave |
| ev_bus_err | output | 1 | STOP arrived after an incomplete byte |
| ev_byte | output | 1 | Eighth bit of a byte clocked in |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench builds the block with its defaults: two synchroniser stages and 8-bit bytes. With two stages the 3-cycle latency of R8 can be checked at an exact cycle. With 8-bit bytes, frames of 0, 5, 8, 9, 10, 12 and 18 clock pulses cover both legal STOP counts, STOPs after a partial first or second byte, and two full bytes. The bench also covers a repeated START, clock pulses outside any frame, and a reset in the middle of a frame.

// File: rtl/twb_mon_pkg.sv
package twb_mon_pkg;
  // One bundle of raw (unregistered) bus events.
  typedef struct packed {
    logic start;
    logic stop;
    logic slave_stop;
    logic bus_err;
    logic byte_done;
  } twb_evt_t;
endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  // Idle bus lines are high, so the stages reset to ones.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '1;
          else        chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/twb_cond_detect.sv
module twb_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  // The clock must be high on both sides of the data edge.
  assign start_det = scl_q & scl & sda_q & ~sda;
  assign stop_det  = scl_q & scl & ~sda_q & sda;
  assign scl_rise  = ~scl_q & scl;
  assign scl_fall  = scl_q & ~scl;
endmodule

// File: rtl/twb_bit_tracker.sv
module twb_bit_tracker #(
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic scl_rise,
  input  logic scl_fall,
  output logic byte_done,
  output logic stop_bad
);
  localparam int CNT_W = $clog2(DATA_BITS + 2);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_BITS - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(DATA_BITS);

  logic             in_frame;
  logic             armed;
  logic [CNT_W-1:0] bit_cnt;

  // A clock pulse only counts when its rise and fall both happen inside
  // the frame. The pulse that frames a START or STOP is dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      armed    <= 1'b0;
      bit_cnt  <= '0;
    end else if (start_det) begin
      in_frame <= 1'b1;
      armed    <= 1'b0;
      bit_cnt  <= '0;
    end else if (stop_det) begin
      in_frame <= 1'b0;
      armed    <= 1'b0;
      bit_cnt  <= '0;
    end else if (in_frame) begin
      if (scl_rise) begin
        armed <= 1'b1;
      end else if (scl_fall && armed) begin
        armed   <= 1'b0;
        bit_cnt <= (bit_cnt == ACK_SLOT) ? '0 : bit_cnt + 1'b1;
      end
    end
  end

  assign byte_done = in_frame & armed & scl_fall & ~start_det & ~stop_det
                   & (bit_cnt == LAST_DATA);
  assign stop_bad  = stop_det & (bit_cnt != '0) & (bit_cnt != ACK_SLOT);
endmodule

// File: rtl/twb_event_irq.sv
module twb_event_irq
  import twb_mon_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  twb_evt_t raw,
  input  logic     monitor_en,
  input  logic     slave_active,
  output twb_evt_t evt_q,
  output logic     irq_q
);
  logic irq_next;

  always_comb begin
    irq_next = raw.bus_err | raw.slave_stop | (raw.byte_done & slave_active);
    if (monitor_en)
      irq_next = irq_next | raw.start | raw.stop | raw.byte_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= raw;
      irq_q <= irq_next;
    end
  end
endmodule

// File: rtl/twb_event_mon.sv
module twb_event_mon
  import twb_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_BITS   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic monitor_en,
  input  logic slave_active,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_slave_stop,
  output logic ev_bus_err,
  output logic ev_byte,
  output logic irq
);
  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       start_det, stop_det, scl_rise, scl_fall;
  logic       byte_done, stop_bad;
  twb_evt_t   raw, evt_q;

  twb_line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({scl_in, sda_in}),
    .d_out (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  twb_cond_detect u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl       (scl_s),
    .sda       (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  twb_bit_tracker #(.DATA_BITS(DATA_BITS)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .byte_done (byte_done),
    .stop_bad  (stop_bad)
  );

  always_comb begin
    raw.start      = start_det;
    raw.stop       = stop_det;
    raw.bus_err    = stop_bad;
    raw.slave_stop = stop_det & slave_active & ~stop_bad;
    raw.byte_done  = byte_done;
  end

  twb_event_irq u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .raw          (raw),
    .monitor_en   (monitor_en),
    .slave_active (slave_active),
    .evt_q        (evt_q),
    .irq_q        (irq)
  );

  assign ev_start      = evt_q.start;
  assign ev_stop       = evt_q.stop;
  assign ev_slave_stop = evt_q.slave_stop;
  assign ev_bus_err    = evt_q.bus_err;
  assign ev_byte       = evt_q.byte_done;
endmodule

// File: rtl/twb_event_mon_chk.sv
module twb_event_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic monitor_en,
  input logic ev_start,
  input logic ev_stop,
  input logic ev_slave_stop,
  input logic ev_bus_err,
  input logic ev_byte,
  input logic irq
);
  a_r1_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !ev_start);

  a_r2_stop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !ev_stop);

  a_r2_no_start_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_start && ev_stop));

  a_r3_byte_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte |=> !ev_byte);

  a_r4_err_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |-> ev_stop);

  a_r5_slave_stop_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ev_slave_stop |-> (ev_stop && !ev_bus_err));

  a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ev_start || ev_stop || ev_byte || ev_bus_err || ev_slave_stop));

  a_r6_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !$past(monitor_en) && !ev_byte && !ev_bus_err && !ev_slave_stop)
      |-> !irq);

  a_r7_mon_start_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && $past(monitor_en)) |-> irq);

  a_r7_mon_stop_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && $past(monitor_en)) |-> irq);

  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !(ev_start || ev_stop || ev_slave_stop || ev_bus_err || ev_byte || irq));
endmodule

bind twb_event_mon twb_event_mon_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .monitor_en    (monitor_en),
  .ev_start      (ev_start),
  .ev_stop       (ev_stop),
  .ev_slave_stop (ev_slave_stop),
  .ev_bus_err    (ev_bus_err),
  .ev_byte       (ev_byte),
  .irq           (irq)
);

// File: tb/twb_event_mon_tb_top.sv
`timescale 1ns/1ps
module twb_event_mon_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic mon = 1'b0, slv = 1'b0;
  logic ev_start, ev_stop, ev_slave_stop, ev_bus_err, ev_byte, irq;

  always #10 clk = ~clk;

  twb_event_mon dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .monitor_en(mon), .slave_active(slv),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_slave_stop(ev_slave_stop),
    .ev_bus_err(ev_bus_err), .ev_byte(ev_byte), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int c_start = 0, c_stop = 0, c_sstop = 0, c_err = 0, c_byte = 0, c_irq = 0;

  always @(negedge clk) begin
    c_start += int'(ev_start);
    c_stop  += int'(ev_stop);
    c_sstop += int'(ev_slave_stop);
    c_err   += int'(ev_bus_err);
    c_byte  += int'(ev_byte);
    c_irq   += int'(irq);
  end

  typedef struct packed {
    logic       mon;
    logic       slv;
    logic [4:0] nclk;
    logic [1:0] e_byte;
    logic       e_err;
    logic       e_sstop;
    logic [2:0] e_irq;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 5'd9,  2'd1, 1'b0, 1'b0, 3'd0},
    '{1'b1, 1'b0, 5'd9,  2'd1, 1'b0, 1'b0, 3'd3},
    '{1'b0, 1'b1, 5'd9,  2'd1, 1'b0, 1'b1, 3'd2},
    '{1'b0, 1'b0, 5'd5,  2'd0, 1'b1, 1'b0, 3'd1},
    '{1'b1, 1'b0, 5'd18, 2'd2, 1'b0, 1'b0, 3'd4},
    '{1'b0, 1'b1, 5'd12, 2'd1, 1'b1, 1'b0, 3'd2},
    '{1'b0, 1'b0, 5'd8,  2'd1, 1'b0, 1'b0, 3'd0},
    '{1'b1, 1'b1, 5'd0,  2'd0, 1'b0, 1'b1, 3'd2},
    '{1'b0, 1'b0, 5'd10, 2'd1, 1'b1, 1'b0, 3'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic lines(input logic c, input logic d);
    @(negedge clk);
    scl = c;
    sda = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_start();  lines(1, 1); lines(1, 0); lines(0, 0); endtask
  task automatic do_stop();   lines(0, 0); lines(1, 0); lines(1, 1); endtask
  task automatic do_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      lines(0, logic'(i % 2));
      lines(1, logic'(i % 2));
      lines(0, logic'(i % 2));
    end
  endtask

  int b_start, b_stop, b_sstop, b_err, b_byte, b_irq;
  task automatic snap();
    b_start = c_start; b_stop = c_stop; b_sstop = c_sstop;
    b_err = c_err; b_byte = c_byte; b_irq = c_irq;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: strobes quiet while reset is held
    check("R9 reset strobes", int'(ev_start | ev_stop | ev_slave_stop | ev_bus_err | ev_byte), 0);
    check("R9 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table of frames: START, nclk clock pulses, STOP
    for (int v = 0; v < NVEC; v++) begin
      mon = VECS[v].mon;
      slv = VECS[v].slv;
      snap();
      do_start();
      do_clocks(int'(VECS[v].nclk));
      do_stop();
      repeat (4) @(negedge clk);
      check("R1 start count", c_start - b_start, 1);
      check("R2 stop count", c_stop - b_stop, 1);
      check("R3 byte count", c_byte - b_byte, int'(VECS[v].e_byte));
      check("R4 bus error", c_err - b_err, int'(VECS[v].e_err));
      check("R5 slave stop", c_sstop - b_sstop, int'(VECS[v].e_sstop));
      check(VECS[v].mon ? "R7 irq count" : "R6 irq count", c_irq - b_irq, int'(VECS[v].e_irq));
    end

    // R8: exact latency from an SDA fall with SCL high
    mon = 1'b0; slv = 1'b0;
    @(negedge clk);
    sda = 1'b0;
    @(negedge clk); check("R8 latency cycle1", int'(ev_start), 0);
    @(negedge clk); check("R8 latency cycle2", int'(ev_start), 0);
    @(negedge clk); check("R8 latency cycle3", int'(ev_start), 1);
    @(negedge clk); check("R8 one cycle wide", int'(ev_start), 0);
    lines(0, 0);
    do_clocks(9);
    do_stop();
    repeat (4) @(negedge clk);

    // R3: clock pulses outside a frame are ignored
    snap();
    do_clocks(8);
    lines(1, 1);
    repeat (4) @(negedge clk);
    check("R3 idle clocks no byte", c_byte - b_byte, 0);

    // R1/R3: repeated START restarts the count
    snap();
    do_start();
    do_clocks(4);
    do_start();
    do_clocks(9);
    do_stop();
    repeat (4) @(negedge clk);
    check("R1 repeated start", c_start - b_start, 2);
    check("R3 restart byte", c_byte - b_byte, 1);
    check("R4 restart no error", c_err - b_err, 0);

    // R9: reset mid-frame clears the count
    snap();
    do_start();
    do_clocks(4);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_clocks(3);
    do_stop();
    repeat (4) @(negedge clk);
    check("R9 reset clears count", c_err - b_err, 0);
    check("R9 stop after reset seen", c_stop - b_stop, 1);
    check("R9 no byte after reset", c_byte - b_byte, 0);

    finish_run();
  end
endmodule